// File: doc/BRIEF.md
# Logic Analyzer Capture Core

This block is the capture engine of a small logic analyzer. On every sample clock it registers a group of input channels and, while a capture is running, writes that sample into an external sample memory at the address held by a free-running counter that wraps. The memory therefore behaves as a ring. The newest samples overwrite the oldest until a trigger fires. After the trigger, a programmed number of further samples are stored, and then writing stops.

The trigger comes from one of two sources. The first is a pattern comparator, in which each channel has an enable bit and a disabled channel matches any value. The second is an external trigger line, for example from a separate sequence-trigger unit. The memory address of the trigger sample is latched. When capture stops, the address counter is frozen on the oldest stored sample, so a host can read the ring in time order starting from the stop address. The post-trigger count sets the split between pre-trigger and post-trigger samples. Half the ring depth puts the trigger in the middle.

The controller has four states:

- `CAP_IDLE`: the state after reset. Nothing is written.
- `CAP_ARMED`: samples are written and the trigger is watched.
- `CAP_POST`: the post-trigger countdown runs.
- `CAP_DONE`: capture is frozen.

It has five transitions:

- `CAP_IDLE` to `CAP_ARMED` on arm.
- `CAP_ARMED` to `CAP_POST` on a trigger with a non-zero count.
- `CAP_ARMED` to `CAP_DONE` on a trigger with a zero count.
- `CAP_POST` to `CAP_DONE` when the last post-trigger sample is written.
- `CAP_DONE` to `CAP_ARMED` on a new arm.

Top module: `la_capture_core`

## Requirements
- R1: During and right after reset the core is in `CAP_IDLE`. `mem_we_o`, `armed_o`, `triggered_o` and `done_o` are 0, and `mem_addr_o` and `trig_addr_o` are 0.
- R2: In `CAP_IDLE`, pattern matches and the external trigger are ignored: `mem_we_o` stays 0 and `mem_addr_o` does not change. A high `arm_i` at a clock edge moves the core to `CAP_ARMED` at that edge.
- R3: In `CAP_ARMED` and `CAP_POST`, `mem_we_o` is 1 on every clock. `mem_data_o` is the `sample_i` value taken at the previous edge. `mem_addr_o` rises by one per written sample and wraps from 32767 to 0.
- R4: The comparator matches when `sample_i` bit i equals `pattern_i` bit i for every i where `mask_i` bit i is 1. Bits with mask 0 are don't-care, so a mask of all zeros matches any sample.
- R5: The trigger decision is registered together with its sample. The sample that caused the trigger is the one written in the `CAP_ARMED` cycle in which the core leaves `CAP_ARMED`.
- R6: With `trig_src_i` = 1 the trigger is `ext_trig_i`, registered in the same way, and comparator matches are ignored. With `trig_src_i` = 0 the comparator is used and `ext_trig_i` is ignored.
- R7: After the trigger sample, exactly `post_count_i` further samples are written (the value is taken at the trigger edge). The core then enters `CAP_DONE`, with `mem_we_o` = 0 and `done_o` = 1.
- R8: With `post_count_i` = 0, the trigger sample is the last sample written and the core goes straight from `CAP_ARMED` to `CAP_DONE`.
- R9: In `CAP_DONE`, `mem_addr_o` holds trigger address + `post_count_i` + 1, modulo 32768. This is the oldest stored sample.
- R10: `arm_i` in `CAP_DONE` restarts capture in `CAP_ARMED`, and the address continues from the stop address. `arm_i` in `CAP_ARMED` or `CAP_POST` has no effect.
- R11: `trig_addr_o` takes the address of the trigger sample. It holds that value through `CAP_POST`, `CAP_DONE` and the following capture, until the next trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Channel inputs |
| pattern_i | input | 8 | Trigger pattern word |
| mask_i | input | 8 | Per-channel trigger enable, 1 = compare |
| trig_src_i | input | 1 | Trigger source select: 0 comparator, 1 external |
| ext_trig_i | input | 1 | External trigger line |
| post_count_i | input | 15 | Samples to store after the trigger sample |
| arm_i | input | 1 | Arm request |
| mem_addr_o | output | 15 | Sample memory write address |
| mem_data_o | output | 8 | Sample memory write data |
| mem_we_o | output | 1 | Sample memory write enable |
| trig_addr_o | output | 15 | Address of the trigger sample |
| armed_o | output | 1 | Core is in `CAP_ARMED` |
| triggered_o | output | 1 | Core is in `CAP_POST` |
| done_o | output | 1 | Core is in `CAP_DONE` |

## Verification
A wrong controller state shows at the ports on the next clock:

- A stray write, or a missing one, appears on `mem_we_o` with a status flag that disagrees.
- A wrong countdown value moves the cycle in which `done_o` rises and changes the frozen address by the same amount.
- A comparator that ignores its mask, or that picks the wrong source, triggers early or late. That moves `trig_addr_o` and the number of writes.
- A counter that skips or stalls is caught by the first write after the fault, because every write is compared with the expected address and data.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_POST  = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_e;

endpackage

// File: rtl/la_sync_counter.sv
module la_sync_counter #(
    parameter int W          = 15,
    parameter bit COUNT_DOWN = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         en_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] step;

    generate
        if (COUNT_DOWN) begin : g_down
            assign step = cnt_q - W'(1);
        end else begin : g_up
            assign step = cnt_q + W'(1);
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (en_i) begin
            cnt_q <= step;
        end
    end

    assign q_o = cnt_q;

    generate
        if (COUNT_DOWN) begin : g_chk_down
            // R7: one count consumed per post-trigger write
            assert_post_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (en_i && !load_i) |=> (q_o == $past(q_o) - W'(1)));
        end else begin : g_chk_up
            // R3: address advances by exactly one per write, wrapping naturally
            assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (en_i && !load_i) |=> (q_o == $past(q_o) + W'(1)));
        end
    endgenerate

    // R9: counter frozen when idle
    assert_hold_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !load_i) |=> $stable(q_o));

endmodule

// File: rtl/la_trig_match.sv
module la_trig_match #(
    parameter int CH = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CH-1:0] sample_i,
    input  logic [CH-1:0] pattern_i,
    input  logic [CH-1:0] mask_i,
    input  logic          src_ext_i,
    input  logic          ext_i,
    output logic [CH-1:0] sample_q_o,
    output logic          hit_q_o
);

    logic [CH-1:0] bit_ok;
    logic          pat_hit;
    logic          hit_d;
    logic [CH-1:0] sample_q;
    logic          hit_q;

    generate
        for (genvar i = 0; i < CH; i++) begin : g_bit
            assign bit_ok[i] = ~mask_i[i] | ~(sample_i[i] ^ pattern_i[i]);
        end
    endgenerate

    assign pat_hit = &bit_ok;
    assign hit_d   = src_ext_i ? ext_i : pat_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sample_q <= '0;
            hit_q    <= 1'b0;
        end else begin
            sample_q <= sample_i;
            hit_q    <= hit_d;
        end
    end

    assign sample_q_o = sample_q;
    assign hit_q_o    = hit_q;

    // R6: the external line, when selected, reaches the decision after one clock
    assert_ext_path_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_ext_i |=> (hit_q_o == $past(ext_i)));

    // R5: sample and decision are captured on the same edge
    assert_sample_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (sample_q_o == $past(sample_i)));

endmodule

// File: rtl/la_capture_fsm.sv
module la_capture_fsm
    import la_cap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       arm_i,
    input  logic       hit_i,
    input  logic       post_zero_i,
    input  logic       rem_one_i,
    output cap_state_e state_o,
    output logic       capture_o,
    output logic       trig_take_o,
    output logic       rem_dec_o
);

    cap_state_e state_q;
    cap_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: begin
                if (arm_i) state_d = CAP_ARMED;
            end
            CAP_ARMED: begin
                if (hit_i) state_d = post_zero_i ? CAP_DONE : CAP_POST;
            end
            CAP_POST: begin
                if (rem_one_i) state_d = CAP_DONE;
            end
            CAP_DONE: begin
                if (arm_i) state_d = CAP_ARMED;
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        capture_o   = 1'b0;
        trig_take_o = 1'b0;
        rem_dec_o   = 1'b0;
        unique case (state_q)
            CAP_IDLE:  ;
            CAP_ARMED: begin
                capture_o   = 1'b1;
                trig_take_o = hit_i;
            end
            CAP_POST: begin
                capture_o = 1'b1;
                rem_dec_o = 1'b1;
            end
            CAP_DONE:  ;
            default:   ;
        endcase
    end

    assign state_o = state_q;

    // R2: idle ignores triggers without an arm request
    assert_idle_stays_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CAP_IDLE && !arm_i) |=> (state_q == CAP_IDLE));

    // R7: the last post-trigger write ends the capture
    assert_post_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CAP_POST && rem_one_i) |=> (state_q == CAP_DONE));

    // R10: arming during the countdown has no effect
    assert_post_ignores_arm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CAP_POST && !rem_one_i) |=> (state_q == CAP_POST));

    // R8: zero post count goes straight to done
    assert_zero_post_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CAP_ARMED && hit_i && post_zero_i) |=> (state_q == CAP_DONE));

endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
    import la_cap_pkg::*;
#(
    parameter int CH     = 8,
    parameter int ADDR_W = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CH-1:0]     sample_i,
    input  logic [CH-1:0]     pattern_i,
    input  logic [CH-1:0]     mask_i,
    input  logic              trig_src_i,
    input  logic              ext_trig_i,
    input  logic [ADDR_W-1:0] post_count_i,
    input  logic              arm_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [CH-1:0]     mem_data_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] trig_addr_o,
    output logic              armed_o,
    output logic              triggered_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [CH-1:0]     sample_q;
    logic              hit_q;
    cap_state_e        state;
    logic              capture;
    logic              trig_take;
    logic              rem_dec;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] rem_q;
    logic [ADDR_W-1:0] trig_addr_q;

    la_trig_match #(.CH(CH)) u_match (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sample_i   (sample_i),
        .pattern_i  (pattern_i),
        .mask_i     (mask_i),
        .src_ext_i  (trig_src_i),
        .ext_i      (ext_trig_i),
        .sample_q_o (sample_q),
        .hit_q_o    (hit_q)
    );

    la_capture_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .arm_i       (arm_i),
        .hit_i       (hit_q),
        .post_zero_i (post_count_i == '0),
        .rem_one_i   (rem_q == ONE),
        .state_o     (state),
        .capture_o   (capture),
        .trig_take_o (trig_take),
        .rem_dec_o   (rem_dec)
    );

    la_sync_counter #(.W(ADDR_W), .COUNT_DOWN(1'b0)) u_addr_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (1'b0),
        .load_val_i ('0),
        .en_i       (capture),
        .q_o        (addr_q)
    );

    la_sync_counter #(.W(ADDR_W), .COUNT_DOWN(1'b1)) u_post_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (trig_take),
        .load_val_i (post_count_i),
        .en_i       (rem_dec),
        .q_o        (rem_q)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trig_addr_q <= '0;
        end else if (trig_take) begin
            trig_addr_q <= addr_q;
        end
    end

    assign mem_addr_o  = addr_q;
    assign mem_data_o  = sample_q;
    assign mem_we_o    = capture;
    assign trig_addr_o = trig_addr_q;
    assign armed_o     = (state == CAP_ARMED);
    assign triggered_o = (state == CAP_POST);
    assign done_o      = (state == CAP_DONE);

    // R11: trigger address is held once taken
    assert_trig_addr_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (triggered_o || done_o) |=> $stable(trig_addr_o));

    // R9: a frozen capture neither writes nor moves
    assert_done_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !arm_i) |=> (!mem_we_o && $stable(mem_addr_o)));

    // R7: entering done from the countdown happens only after the last write
    assert_done_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(mem_we_o));

endmodule

// File: tb/tb_la_capture_core.sv
module tb_la_capture_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sample = '0, pat = '0, msk = '0;
    logic        src = 1'b0, ext = 1'b0, arm = 1'b0;
    logic [14:0] post = '0;
    logic [14:0] mem_addr, trig_addr;
    logic [7:0]  mem_data;
    logic        mem_we, armed, triggered, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    la_capture_core dut (
        .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .pattern_i(pat),
        .mask_i(msk), .trig_src_i(src), .ext_trig_i(ext), .post_count_i(post),
        .arm_i(arm), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_we_o(mem_we),
        .trig_addr_o(trig_addr), .armed_o(armed), .triggered_o(triggered), .done_o(done)
    );

    typedef struct {
        logic        we;
        logic [14:0] addr;
        logic [7:0]  data;
        logic [2:0]  flags;
        logic [14:0] taddr;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    // reference model registers (0 idle, 1 armed, 2 post, 3 done)
    int          m_st = 0;
    logic [14:0] m_addr = '0, m_rem = '0, m_taddr = '0;
    logic [7:0]  m_smp = '0;
    logic        m_hit = 1'b0;

    // Driver: applies one cycle of stimulus and predicts the outputs after the next edge
    task automatic drive(input logic [7:0] s, input logic a, input logic e, input string req);
        int          ns;
        logic [14:0] na, nr, nt;
        logic        nh, cap;
        exp_t        it;
        sample = s; arm = a; ext = e;
        cap = (m_st == 1) || (m_st == 2);
        ns = m_st; nr = m_rem; nt = m_taddr;
        case (m_st)
            0: if (a) ns = 1;
            1: if (m_hit) begin
                   ns = (post == 0) ? 3 : 2;
                   nr = post;
                   nt = m_addr;
               end
            2: begin
                   nr = m_rem - 15'd1;
                   if (m_rem == 15'd1) ns = 3;
               end
            default: if (a) ns = 1;
        endcase
        na = cap ? m_addr + 15'd1 : m_addr;
        nh = src ? e : (((s ^ pat) & msk) == 8'h00);
        m_st = ns; m_addr = na; m_rem = nr; m_taddr = nt; m_smp = s; m_hit = nh;
        it.we    = (ns == 1) || (ns == 2);
        it.addr  = na;
        it.data  = s;
        it.flags = {ns == 3, ns == 2, ns == 1};
        it.taddr = nt;
        it.req   = req;
        exp_q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    // Monitor: pops one expected item per clock and compares the ports
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                checks++;
                if (mem_we !== it.we || mem_addr !== it.addr ||
                    (it.we && mem_data !== it.data) ||
                    {done, triggered, armed} !== it.flags || trig_addr !== it.taddr) begin
                    errors++;
                    $display("FAIL %s: we=%b addr=%0d data=%h flags=%b taddr=%0d expected we=%b addr=%0d data=%h flags=%b taddr=%0d",
                             it.req, mem_we, mem_addr, mem_data, {done, triggered, armed}, trig_addr,
                             it.we, it.addr, it.data, it.flags, it.taddr);
                end
            end
        end
    end

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs during reset
        checks++;
        if (mem_we !== 1'b0 || mem_addr !== '0 || trig_addr !== '0 || {done, triggered, armed} !== 3'b000) begin
            errors++;
            $display("FAIL R1: we=%b addr=%0d taddr=%0d flags=%b expected all zero",
                     mem_we, mem_addr, trig_addr, {done, triggered, armed});
        end
        rst_n = 1'b1;

        // R2: matching samples and external pulses while idle
        pat = 8'hA5; msk = 8'hFF; post = 15'd5; src = 1'b0;
        drive(8'hA5, 1'b0, 1'b1, "R1");
        drive(8'hA5, 1'b0, 1'b1, "R2");
        drive(8'hA5, 1'b0, 1'b0, "R2");
        drive(8'h00, 1'b0, 1'b1, "R2");

        // R4 R5: masked comparator, upper nibble only
        msk = 8'hF0;
        drive(8'h11, 1'b1, 1'b0, "R2");
        drive(8'h5A, 1'b0, 1'b0, "R4");
        drive(8'h00, 1'b0, 1'b1, "R4 R6");
        drive(8'hB5, 1'b0, 1'b0, "R4");
        drive(8'hA3, 1'b0, 1'b0, "R5");
        drive(8'h01, 1'b0, 1'b0, "R11");
        drive(8'h02, 1'b1, 1'b0, "R10");
        drive(8'h03, 1'b0, 1'b0, "R7");
        drive(8'h04, 1'b1, 1'b0, "R10");
        drive(8'h05, 1'b0, 1'b0, "R7");
        drive(8'h06, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 4; i++) drive(8'hA5, 1'b0, 1'b0, "R9");

        // R6 R8: re-arm from done, external source, zero post count
        post = 15'd0; src = 1'b1;
        drive(8'hA5, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 4; i++) drive(8'hA5, 1'b0, 1'b0, "R6");
        drive(8'h77, 1'b0, 1'b1, "R6");
        drive(8'h78, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 3; i++) drive(8'h79, 1'b0, 1'b1, "R8 R9");

        // R3: full-ring wrap, mask zero matches anything
        src = 1'b0; msk = 8'h00; post = 15'h7FFF;
        drive(8'h10, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 32775; i++) drive(i[7:0], 1'b0, 1'b0, "R3");
        for (int i = 0; i < 3; i++) drive(8'hFF, 1'b0, 1'b0, "R9 R11");

        repeat (3) @(posedge clk);
        #3;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R3: %0d expected items left, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule